// File: doc/BRIEF.md
# Refresh-Guarded Watchdog Counter

This block is a watchdog for a small microcontroller. Once software starts it, an up-counter advances on a divided clock, and software must reload it before it rolls over from all-ones. If it rolls over, the block latches an expiry status bit and drives a fixed-length reset pulse toward the chip's reset tree.

A reload only happens through a strict two-write handshake. Software first writes the arm strobe, and its very next register write must be the start strobe. A start write that does not follow an arm write directly still starts an idle watchdog, but it never reloads the counter. A reload loads the upper part of the counter from the reload register and clears the lower part. The top bit of the reload register adds a divide-by-16 stage after the base divide-by-2.

The expiry status bit has its own power-on reset, so it survives the reset pulse it causes. Software can read it and clear it with a write.

Top module: `wdg_guard`

## Requirements
- R1: After `por_n` and `rst_n` are both held low, `wd_reset`, `expired`, `start_flag` and `run_active` are 0 and `reload_q` is 0.
- R2: Until a start write arrives, the counter does not advance and no expiry occurs, whatever the reload register holds.
- R3: A start write that does not follow an arm write directly does not reload the counter. The pending expiry time is unchanged.
- R4: A start write whose previous register write was an arm write reloads the counter with {reload_q[HI_W-1:0], LO_W zeros}. Expiry then falls exactly (2^HI_W - reload) * 2^LO_W counter ticks after that start write's clock edge. Clock cycles with no writes between the arm write and the start write do not break the handshake.
- R5: A reload-register write or a status-clear write between the arm write and the start write cancels the handshake, so that start write does not reload the counter.
- R6: `start_flag` goes to 1 on the edge that samples a start write and stays 1 for exactly 12 clock cycles, then clears by itself.
- R7: Counter ticks come every 2 clock cycles when `reload_q[HI_W]` is 0, and every 32 clock cycles when it is 1. The prescaler restarts at every reload and at activation.
- R8: On rollover, `expired` goes to 1 and `wd_reset` is 1 for exactly 4 consecutive cycles, both starting after the overflow edge.
- R9: `expired` is not cleared by `rst_n`. A status-clear write clears it, and so does `por_n`.
- R10: After an expiry, `run_active` is 0 and the counter stays stopped until the next start write.
- R11: A reload-register write is visible on `reload_q` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset (does not clear the expiry bit) |
| por_n | input | 1 | Synchronous active-low power-on reset for the expiry bit and the pulse generator |
| arm_wr | input | 1 | Write strobe for the arm bit |
| start_wr | input | 1 | Write strobe for the start/refresh bit |
| reload_wr | input | 1 | Write strobe for the reload register |
| reload_wdata | input | HI_W+1 (8) | Reload register data: top bit selects the extra divider, the rest is the reload value |
| stat_clr_wr | input | 1 | Write strobe that clears the expiry bit |
| reload_q | output | HI_W+1 (8) | Reload register read-back |
| start_flag | output | 1 | Self-clearing start/refresh flag |
| run_active | output | 1 | Watchdog is counting |
| expired | output | 1 | Sticky expiry status |
| wd_reset | output | 1 | Reset request pulse |

## Verification
On every cycle, the assertions check the following. The counter holds still when there is neither a tick nor a reload. Ticks are never back to back. A start write always raises the flag. A start write right after a reload or clear write never reloads. The reset pulse lasts more than one cycle. The expiry bit only drops on a clear write or a power-on reset. The bench scenarios show the timing that only shows up as a whole expiry interval. This covers the exact rollover edge for every reload value under both dividers, the 12-cycle self-clear, and the expiry time being unchanged by a bare or interrupted start.

// File: rtl/wdg_pkg.sv
// Shared constants and types for the refresh-guarded watchdog.
// Assumes: all widths and divider ratios are powers of two where noted.
package wdg_pkg;
    // Cycles the start/refresh flag stays set before hardware clears it.
    localparam int unsigned SELF_CLR_CYCLES = 12;
    // Length of the reset request pulse, in clock cycles.
    localparam int unsigned RST_PULSE_CYCLES = 4;

    // State of the two-write refresh handshake.
    typedef enum logic {
        HS_IDLE  = 1'b0,
        HS_ARMED = 1'b1
    } hs_state_t;
endpackage

// File: rtl/wdg_prescale.sv
// Counter clock-enable generator: base divider with an optional extra
// stage cascaded after it. Assumes BASE_DIV >= 2 and both ratios are
// powers of two. The divider is held at zero while the watchdog is idle
// and restarts on every reload, so intervals are exact.
module wdg_prescale #(
    parameter int unsigned BASE_DIV = 2,
    parameter int unsigned EXT_DIV  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic ext_sel,
    output logic tick
);
    localparam int unsigned FULL_DIV = BASE_DIV * EXT_DIV;
    localparam int unsigned PRE_W    = (FULL_DIV > 2) ? $clog2(FULL_DIV) : 1;
    localparam int unsigned BASE_W   = $clog2(BASE_DIV);

    logic [PRE_W-1:0] pre_q;

    // Free-running divide count while running; cleared when idle or on reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || restart) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    generate
        if (EXT_DIV > 1) begin : g_ext
            // Extra stage present: select terminal count by ext_sel.
            always_comb begin
                if (ext_sel) begin
                    tick = run && (pre_q == PRE_W'(FULL_DIV - 1));
                end else begin
                    tick = run && (pre_q[BASE_W-1:0] == BASE_W'(BASE_DIV - 1));
                end
            end
        end else begin : g_base
            // No extra stage: only the base terminal count exists.
            logic unused_sel;
            assign unused_sel = ext_sel;
            always_comb begin
                tick = run && (pre_q[BASE_W-1:0] == BASE_W'(BASE_DIV - 1));
            end
        end
    endgenerate

    // R7: two ticks never come on consecutive cycles.
    assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("tick on consecutive cycles");
endmodule

// File: rtl/wdg_seq.sv
// Refresh handshake, run control and self-clearing start flag.
// Assumes each strobe is a single-cycle write pulse from the bus decoder;
// other_wr covers every other register write of the block.
module wdg_seq
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_wr,
    input  logic start_wr,
    input  logic other_wr,
    input  logic expire,
    output logic refresh,
    output logic run_q,
    output logic start_flag
);
    localparam int unsigned CLR_W = $clog2(SELF_CLR_CYCLES);

    hs_state_t        hs_q;
    logic [CLR_W-1:0] clr_cnt_q;
    logic             any_wr;

    assign any_wr  = arm_wr | start_wr | other_wr;
    assign refresh = start_wr && (hs_q == HS_ARMED);

    // Track whether the last register write was a lone arm write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= HS_IDLE;
        end else if (arm_wr && !start_wr && !other_wr) begin
            hs_q <= HS_ARMED;
        end else if (any_wr || expire) begin
            hs_q <= HS_IDLE;
        end
    end

    // Running from the first start write until an expiry stops it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (expire) begin
            run_q <= 1'b0;
        end else if (start_wr) begin
            run_q <= 1'b1;
        end
    end

    // Start flag: set by a start write, cleared after the fixed hold time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_flag <= 1'b0;
            clr_cnt_q  <= '0;
        end else if (start_wr) begin
            start_flag <= 1'b1;
            clr_cnt_q  <= CLR_W'(SELF_CLR_CYCLES - 1);
        end else if (start_flag) begin
            if (clr_cnt_q == '0) begin
                start_flag <= 1'b0;
            end else begin
                clr_cnt_q <= clr_cnt_q - 1'b1;
            end
        end
    end

    // R6: a start write always leaves the flag set on the next cycle.
    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> start_flag)
        else $error("start flag not set after start write");
endmodule

// File: rtl/wdg_count.sv
// Watchdog up-counter: upper part reloadable, lower part cleared on reload.
// Assumes tick is a one-cycle enable. Overflow from all-ones is the expiry
// event; a reload in the same cycle takes precedence and suppresses it.
module wdg_count #(
    parameter int unsigned HI_W = 7,
    parameter int unsigned LO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            refresh,
    input  logic [HI_W-1:0] reload_hi,
    output logic            overflow
);
    localparam int unsigned CNT_W = HI_W + LO_W;

    logic [CNT_W-1:0] cnt_q;

    assign overflow = tick && (&cnt_q) && !refresh;

    // Reload the upper part, or advance by one per tick (wrapping to zero).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (refresh) begin
            cnt_q <= {reload_hi, {LO_W{1'b0}}};
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: without a tick or a reload the count does not move.
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !refresh) |=> $stable(cnt_q))
        else $error("counter moved without tick or reload");
endmodule

// File: rtl/wdg_rstgen.sv
// Expiry status bit and reset request pulse. Both live on the power-on
// reset only, so the reset they request does not erase or cut them short.
module wdg_rstgen
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic expire,
    input  logic stat_clr,
    output logic status,
    output logic wd_reset
);
    localparam int unsigned PULSE_W = $clog2(RST_PULSE_CYCLES + 1);

    logic [PULSE_W-1:0] pulse_q;

    // Sticky expiry bit: set wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            status <= 1'b0;
        end else if (expire) begin
            status <= 1'b1;
        end else if (stat_clr) begin
            status <= 1'b0;
        end
    end

    // Pulse length counter: loaded on expiry, counts down to zero.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            pulse_q <= '0;
        end else if (expire) begin
            pulse_q <= PULSE_W'(RST_PULSE_CYCLES);
        end else if (pulse_q != '0) begin
            pulse_q <= pulse_q - 1'b1;
        end
    end

    assign wd_reset = (pulse_q != '0);

    // R8: the reset pulse is never a single cycle.
    assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wd_reset) |=> wd_reset)
        else $error("reset pulse too short");

    // R9: the status bit only drops on a clear write.
    assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
        (status && !stat_clr) |=> status)
        else $error("status dropped without clear");
endmodule

// File: rtl/wdg_guard.sv
// Top of the refresh-guarded watchdog. Holds the reload register and wires
// the handshake, prescaler, counter and reset generator together.
// Assumes strobes are single-cycle pulses from an external bus decoder and
// that the reset tree feeds rst_n, while por_n comes from power-on only.
module wdg_guard #(
    parameter int unsigned HI_W     = 7,
    parameter int unsigned LO_W     = 8,
    parameter int unsigned BASE_DIV = 2,
    parameter int unsigned EXT_DIV  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            por_n,
    input  logic            arm_wr,
    input  logic            start_wr,
    input  logic            reload_wr,
    input  logic [HI_W:0]   reload_wdata,
    input  logic            stat_clr_wr,
    output logic [HI_W:0]   reload_q,
    output logic            start_flag,
    output logic            run_active,
    output logic            expired,
    output logic            wd_reset
);
    localparam int unsigned RLD_W = HI_W + 1;

    logic             refresh;
    logic             run_q;
    logic             tick;
    logic             overflow;
    logic             other_wr;
    logic [RLD_W-1:0] rld_q;

    assign other_wr   = reload_wr | stat_clr_wr;
    assign reload_q   = rld_q;
    assign run_active = run_q;

    // Reload register: divider select in the top bit, reload value below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q <= '0;
        end else if (reload_wr) begin
            rld_q <= reload_wdata;
        end
    end

    wdg_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_wr     (arm_wr),
        .start_wr   (start_wr),
        .other_wr   (other_wr),
        .expire     (overflow),
        .refresh    (refresh),
        .run_q      (run_q),
        .start_flag (start_flag)
    );

    wdg_prescale #(
        .BASE_DIV (BASE_DIV),
        .EXT_DIV  (EXT_DIV)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .restart (refresh),
        .ext_sel (rld_q[HI_W]),
        .tick    (tick)
    );

    wdg_count #(
        .HI_W (HI_W),
        .LO_W (LO_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .refresh   (refresh),
        .reload_hi (rld_q[HI_W-1:0]),
        .overflow  (overflow)
    );

    wdg_rstgen u_rst (
        .clk      (clk),
        .por_n    (por_n),
        .expire   (overflow),
        .stat_clr (stat_clr_wr),
        .status   (expired),
        .wd_reset (wd_reset)
    );

    // R5: a start write right after another register write never reloads.
    assert_disarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && $past(other_wr)) |-> !refresh)
        else $error("reload after interrupted handshake");
endmodule

// File: tb/wdg_guard_test.sv
// Self-checking bench on a small configuration: 3-bit upper part and
// 2-bit lower part, with the base divider of 2 and extra divider of 16.
module wdg_guard_test;
    localparam int HI = 3;
    localparam int LO = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          por_n = 1'b0;
    logic          arm_wr = 1'b0;
    logic          start_wr = 1'b0;
    logic          reload_wr = 1'b0;
    logic [HI:0]   reload_wdata = '0;
    logic          stat_clr_wr = 1'b0;
    logic [HI:0]   reload_q;
    logic          start_flag;
    logic          run_active;
    logic          expired;
    logic          wd_reset;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    wdg_guard #(.HI_W(HI), .LO_W(LO), .BASE_DIV(2), .EXT_DIV(16)) uut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .arm_wr(arm_wr),
        .start_wr(start_wr), .reload_wr(reload_wr), .reload_wdata(reload_wdata),
        .stat_clr_wr(stat_clr_wr), .reload_q(reload_q), .start_flag(start_flag),
        .run_active(run_active), .expired(expired), .wd_reset(wd_reset)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Every write task is entered at a negedge and spends one clock edge.
    task automatic wr_arm();
        arm_wr = 1'b1; @(negedge clk); arm_wr = 1'b0;
    endtask
    task automatic wr_start();
        start_wr = 1'b1; @(negedge clk); start_wr = 1'b0;
    endtask
    task automatic wr_reload(input logic [HI:0] v);
        reload_wdata = v; reload_wr = 1'b1; @(negedge clk); reload_wr = 1'b0;
    endtask
    task automatic wr_clear();
        stat_clr_wr = 1'b1; @(negedge clk); stat_clr_wr = 1'b0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    // Edges until wd_reset is seen high (gives up after 5000).
    task automatic wait_rise(output int n);
        n = 0;
        while (wd_reset !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask
    // Let a pending pulse finish and clear the status bit.
    task automatic settle();
        idle(6);
        wr_clear();
    endtask

    function automatic int exp_edges(input int rv, input int ps);
        return (2**HI - rv) * (2**LO) * (ps ? 32 : 2);
    endfunction

    initial begin
        #1_500_000;
        failures++;
        $display("FAIL watchdog timeout");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        idle(3);
        rst_n = 1'b1; por_n = 1'b1;
        // R1: reset state
        chk(wd_reset == 0 && expired == 0, "R1 reset outputs", {wd_reset, expired}, 0);
        chk(start_flag == 0 && run_active == 0, "R1 reset control", {start_flag, run_active}, 0);
        chk(reload_q == 0, "R1 reload reset", reload_q, 0);

        // R2: no start, short reload programmed -> never expires
        wr_reload(4'h7);
        begin
            int seen = 0;
            for (int i = 0; i < 1500; i++) begin
                @(negedge clk);
                if (wd_reset || run_active || expired) seen++;
            end
            chk(seen == 0, "R2 idle without start", seen, 0);
        end

        // R6 + activation from zero: bare start starts counter from 0
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        wr_start();
        chk(start_flag == 1, "R6 flag set", start_flag, 1);
        begin
            int low = 0;
            for (int i = 0; i < 11; i++) begin
                @(negedge clk);
                if (!start_flag) low++;
            end
            chk(low == 0, "R6 flag held 12 cycles", low, 0);
        end
        idle(1);
        chk(start_flag == 0, "R6 flag self-clear", start_flag, 0);
        wait_rise(n);
        chk(12 + n == exp_edges(0, 0), "R2 start activates from zero", 12 + n, exp_edges(0, 0));
        settle();

        // R4/R7/R8/R10/R11/R9: sweep all reload values under both dividers
        for (int ps = 0; ps < 2; ps++) begin
            for (int rv = 0; rv < 2**HI; rv++) begin
                logic [HI:0] v;
                v = {ps[0], rv[HI-1:0]};
                wr_reload(v);
                chk(reload_q == v, "R11 reload readback", reload_q, v);
                wr_arm();
                wr_start();
                wait_rise(n);
                chk(n == exp_edges(rv, ps), ps ? "R4 R7 expiry time ext" : "R4 R7 expiry time base",
                    n, exp_edges(rv, ps));
                chk(expired == 1, "R8 status set", expired, 1);
                begin
                    int low = 0;
                    for (int i = 0; i < 3; i++) begin
                        @(negedge clk);
                        if (!wd_reset) low++;
                    end
                    chk(low == 0, "R8 pulse held", low, 0);
                end
                idle(1);
                chk(wd_reset == 0, "R8 pulse ends after 4", wd_reset, 0);
                chk(run_active == 0, "R10 stopped after expiry", run_active, 0);
                wr_clear();
                chk(expired == 0, "R9 clear write", expired, 0);
            end
        end

        // R10: stays stopped after expiry
        wr_reload(4'h6); wr_arm(); wr_start();
        wait_rise(n);
        settle();
        begin
            int seen = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (wd_reset || run_active) seen++;
            end
            chk(seen == 0, "R10 no restart without start", seen, 0);
        end

        // R3: bare start mid-interval does not reload (R=6: 16 edges)
        wr_reload(4'h6); wr_arm(); wr_start();
        idle(4);
        wr_start();
        wait_rise(n);
        chk(5 + n == 16, "R3 bare start ignored", 5 + n, 16);
        settle();

        // R5: reload write between arm and start cancels (R=4: 32 edges)
        wr_reload(4'h4); wr_arm(); wr_start();
        idle(3);
        wr_arm(); wr_reload(4'h4); wr_start();
        wait_rise(n);
        chk(6 + n == 32, "R5 reload write disarms", 6 + n, 32);
        settle();

        // R5: clear write between arm and start cancels
        wr_reload(4'h4); wr_arm(); wr_start();
        idle(3);
        wr_arm(); wr_clear(); wr_start();
        wait_rise(n);
        chk(6 + n == 32, "R5 clear write disarms", 6 + n, 32);
        settle();

        // R4: idle cycles between arm and start keep the handshake
        wr_reload(4'h0); wr_arm(); wr_start();
        idle(3);
        wr_reload(4'h6); wr_arm(); idle(2); wr_start();
        wait_rise(n);
        chk(8 + n == 24, "R4 gap keeps handshake", 8 + n, 24);

        // R9: expired survives rst_n, cleared by por_n
        idle(6);
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        chk(expired == 1, "R9 survives system reset", expired, 1);
        chk(reload_q == 0 && run_active == 0, "R1 system reset state", reload_q, 0);
        por_n = 1'b0; idle(1); por_n = 1'b1;
        chk(expired == 0, "R9 power-on clears", expired, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule